// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a start/stop framed serial line back into characters. A single-cycle enable, `tick`, arrives at sixteen times the bit rate and drives all of its timing. The receiver watches the idle-high line for a falling edge. It checks that the start bit is still low half a bit later, then samples every following bit at the centre of its sixteen-tick window, least significant bit first.

Five configuration inputs set the frame layout, and they are captured when the start edge is seen. The inputs select a 7- or 8-bit character, whether a parity bit follows, whether the bit after the data is an address/data marker, whether one or two stop bits follow, and whether the parity sense is even or odd. After the last stop sample the block loads one holding register with the character, a parity-error flag, a framing-error flag and the marker bit, and pulses `rx_valid` for one clock.

Top module: `async_frame_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `rx_valid`, `rx_data`, `err_parity`, `err_frame` and `mp_flag` are all 0, and the line is treated as idle high.
- R2: Only a high-to-low transition of the line seen on consecutive ticks starts a frame. If the line is high again at the eighth tick after that transition, the frame is dropped and no `rx_valid` pulse is produced.
- R3: Data bits are sampled every 16 ticks after the start-bit centre, least significant bit first. With `cfg_short` = 0, eight bits are received into `rx_data[7:0]`.
- R4: With `cfg_short` = 1, seven bits are received into `rx_data[6:0]` and `rx_data[7]` reads 0.
- R5: A parity bit follows the data only when `cfg_par_en` = 1 and `cfg_mp` = 0. In that case `err_parity` is 1 exactly when the count of ones across the data bits and the parity bit is odd with `cfg_par_odd` = 0, or even with `cfg_par_odd` = 1. In every other configuration `err_parity` is 0.
- R6: With `cfg_mp` = 1, the bit after the data is returned on `mp_flag` and no parity check is made. With `cfg_mp` = 0, `mp_flag` is 0.
- R7: One stop bit is expected with `cfg_two_stop` = 0 and two with `cfg_two_stop` = 1. `err_frame` is 1 when any expected stop bit is sampled low.
- R8: `rx_valid` is high for exactly one clock, on the edge that follows the tick carrying the final stop sample. `rx_data` and all flags change on that same edge and hold until the next pulse.
- R9: Nothing advances in a clock without `tick`. Line activity while `tick` stays low produces no frame.
- R10: The configuration inputs are captured at the start edge. Changing them during a frame does not alter how that frame is parsed or checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| cfg_short | input | 1 | 1 = 7-bit character, 0 = 8-bit |
| cfg_par_en | input | 1 | Parity bit present (ignored when cfg_mp = 1) |
| cfg_mp | input | 1 | Bit after the data is a marker, not parity |
| cfg_two_stop | input | 1 | 1 = two stop bits expected |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-clock pulse when a frame completes |
| err_parity | output | 1 | Parity mismatch on the last frame |
| err_frame | output | 1 | A stop bit was sampled low on the last frame |
| mp_flag | output | 1 | Marker bit from the last frame |

## Verification
A result is due a fixed number of ticks after the start edge: half a bit plus sixteen ticks for each bit after the start bit, then one clock. The line synchronizer and the tick phase add a few clocks of uncertainty on top. For each frame the bench records the clock count of the start edge and requires exactly one `rx_valid` inside a window a few clocks wide at that computed position. It reads data and flags at the same negative edge as the pulse and compares them with values worked out from the transmitted bits. Cases that must produce no frame (a short glitch, activity with no tick) are checked by confirming that the pulse count stays unchanged across a quiet period longer than a frame.

// File: rtl/afr_pkg.sv
package afr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_EXTRA,
      ST_STOP
   } afr_state_e;

   typedef struct packed {
      logic short_char;
      logic par_en;
      logic mp_mode;
      logic two_stop;
      logic par_odd;
   } afr_cfg_t;
endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) q[g] <= 1'b1;
            else        q[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) q[g] <= 1'b1;
            else        q[g] <= q[g-1];
         end
      end
   end

   assign dout = q[STAGES-1];
endmodule

// File: rtl/afr_seq.sv
module afr_seq
   import afr_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  afr_cfg_t   cfg_in,
   output afr_state_e state,
   output afr_cfg_t   cfg,
   output logic       samp,
   output logic       start_ok,
   output logic       last
);
   localparam int CW  = $clog2(OVS);
   localparam int MID = OVS / 2;
   localparam int BW  = $clog2(DATA_W + 1);

   logic [CW-1:0] cnt;
   logic [BW-1:0] bitn;
   logic [BW-1:0] nbits;
   logic          prev;
   logic          at_end;
   logic          in_bits;

   always_comb begin
      at_end   = (cnt == CW'(OVS - 1));
      in_bits  = (state == ST_DATA) || (state == ST_EXTRA) || (state == ST_STOP);
      samp     = tick && at_end && in_bits;
      start_ok = tick && (state == ST_START) && (cnt == CW'(MID - 1)) && !line;
      nbits    = cfg.short_char ? BW'(DATA_W - 1) : BW'(DATA_W);
      last     = samp && (state == ST_STOP) && (!cfg.two_stop || (bitn != '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         prev  <= 1'b1;
         cfg   <= '0;
      end else if (tick) begin
         case (state)
            ST_IDLE: begin
               prev <= line;
               if (prev && !line) begin
                  state <= ST_START;
                  cnt   <= '0;
                  cfg   <= cfg_in;
               end
            end
            ST_START: begin
               if (cnt == CW'(MID - 1)) begin
                  cnt  <= '0;
                  bitn <= '0;
                  if (!line) begin
                     state <= ST_DATA;
                  end else begin
                     state <= ST_IDLE;
                     prev  <= line;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (!at_end) begin
                  cnt <= cnt + 1'b1;
               end else begin
                  cnt <= '0;
                  case (state)
                     ST_DATA: begin
                        if (bitn == nbits - 1'b1) begin
                           bitn  <= '0;
                           state <= (cfg.par_en || cfg.mp_mode) ? ST_EXTRA : ST_STOP;
                        end else begin
                           bitn <= bitn + 1'b1;
                        end
                     end
                     ST_EXTRA: begin
                        bitn  <= '0;
                        state <= ST_STOP;
                     end
                     ST_STOP: begin
                        if (cfg.two_stop && (bitn == '0)) begin
                           bitn <= BW'(1);
                        end else begin
                           state <= ST_IDLE;
                           prev  <= line;
                        end
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/afr_capture.sv
module afr_capture
   import afr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line,
   input  afr_state_e        state,
   input  afr_cfg_t          cfg,
   input  logic              samp,
   input  logic              start_ok,
   input  logic              last,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              err_parity,
   output logic              err_frame,
   output logic              mp_flag
);
   logic [DATA_W-1:0] sh;
   logic              xbit;
   logic              stop_bad;
   logic [DATA_W-1:0] word;
   logic              par_mis;
   logic              chk_par;

   always_comb begin
      word    = cfg.short_char ? {1'b0, sh[DATA_W-1:1]} : sh;
      par_mis = ((^word) ^ xbit) != cfg.par_odd;
      chk_par = cfg.par_en && !cfg.mp_mode;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh         <= '0;
         xbit       <= 1'b0;
         stop_bad   <= 1'b0;
         rx_data    <= '0;
         rx_valid   <= 1'b0;
         err_parity <= 1'b0;
         err_frame  <= 1'b0;
         mp_flag    <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (start_ok) begin
            sh       <= '0;
            xbit     <= 1'b0;
            stop_bad <= 1'b0;
         end
         if (samp) begin
            case (state)
               ST_DATA:  sh       <= {line, sh[DATA_W-1:1]};
               ST_EXTRA: xbit     <= line;
               ST_STOP:  stop_bad <= stop_bad | !line;
               default:  ;
            endcase
         end
         if (last) begin
            rx_valid   <= 1'b1;
            rx_data    <= word;
            err_frame  <= stop_bad | !line;
            err_parity <= chk_par && par_mis;
            mp_flag    <= cfg.mp_mode && xbit;
         end
      end
   end
endmodule

// File: rtl/async_frame_rx.sv
module async_frame_rx
   import afr_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              cfg_short,
   input  logic              cfg_par_en,
   input  logic              cfg_mp,
   input  logic              cfg_two_stop,
   input  logic              cfg_par_odd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              err_parity,
   output logic              err_frame,
   output logic              mp_flag
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic       line;
   afr_state_e state;
   afr_cfg_t   cfg_in;
   afr_cfg_t   cfg_q;
   logic       samp;
   logic       start_ok;
   logic       last;

   assign cfg_in = '{short_char: cfg_short, par_en: cfg_par_en, mp_mode: cfg_mp,
                     two_stop: cfg_two_stop, par_odd: cfg_par_odd};

   afr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (line)
   );

   afr_seq #(.OVS(OVS), .DATA_W(DATA_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .line    (line),
      .cfg_in  (cfg_in),
      .state   (state),
      .cfg     (cfg_q),
      .samp    (samp),
      .start_ok(start_ok),
      .last    (last)
   );

   afr_capture #(.DATA_W(DATA_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (line),
      .state     (state),
      .cfg       (cfg_q),
      .samp      (samp),
      .start_ok  (start_ok),
      .last      (last),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .err_parity(err_parity),
      .err_frame (err_frame),
      .mp_flag   (mp_flag)
   );
endmodule

// File: rtl/afr_checker.sv
module afr_checker
   import afr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              err_parity,
   input logic              mp_flag,
   input afr_cfg_t          cfg
);
   p_valid_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_data_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> rx_valid);

   p_valid_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(tick));

   p_short_msb_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg.short_char) |-> !rx_data[DATA_W-1]);

   p_mp_no_perr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg.mp_mode) |-> !err_parity);

   p_mp_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg.mp_mode) |-> !mp_flag);

   p_no_parity_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg.par_en) |-> !err_parity);
endmodule

bind async_frame_rx afr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .err_parity(err_parity),
   .mp_flag   (mp_flag),
   .cfg       (cfg_q)
);

// File: tb/sim_async_frame_rx.sv
module sim_async_frame_rx;
   localparam int CLK_PERIOD = 10;
   localparam int TDIV       = 2;
   localparam int BITC       = 16 * TDIV;
   localparam int WD_CYCLES  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick;
   logic       tick_en = 1'b1;
   logic       rxd = 1'b1;
   logic       cfg_short = 1'b0, cfg_par_en = 1'b0, cfg_mp = 1'b0;
   logic       cfg_two_stop = 1'b0, cfg_par_odd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid, err_parity, err_frame, mp_flag;

   int         nvec = 0, nfail = 0, cyc = 0, vcnt = 0, vcyc = 0, tcnt = 0;
   logic [7:0] cap_d;
   logic       cap_p, cap_f, cap_m;
   bit         done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   async_frame_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_mp(cfg_mp),
      .cfg_two_stop(cfg_two_stop), .cfg_par_odd(cfg_par_odd),
      .rx_data(rx_data), .rx_valid(rx_valid), .err_parity(err_parity),
      .err_frame(err_frame), .mp_flag(mp_flag)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) tcnt <= 0;
      else tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
   end
   assign tick = rst_n && tick_en && (tcnt == TDIV - 1);

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         vcnt  <= vcnt + 1;
         vcyc  <= cyc;
         cap_d <= rx_data;
         cap_p <= err_parity;
         cap_f <= err_frame;
         cap_m <= mp_flag;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive_bit(input logic b);
      rxd = b;
      repeat (BITC) @(negedge clk);
   endtask

   // m = {short, par_en, mp, two_stop, par_odd}
   task automatic run_frame(input logic [7:0] d, input logic [4:0] m, input logic bad_par,
                            input logic [1:0] bad_stop, input logic mpb, input logic flip);
      logic       sh, pe, mp, two, odd, pbit, xb, extra;
      logic [7:0] dm, exp_d;
      int         nb, total, lo, vbase, c0;
      {sh, pe, mp, two, odd} = m;
      {cfg_short, cfg_par_en, cfg_mp, cfg_two_stop, cfg_par_odd} = m;
      nb    = sh ? 7 : 8;
      dm    = sh ? (d & 8'h7F) : d;
      pbit  = (^dm) ^ odd ^ bad_par;
      extra = pe || mp;
      xb    = mp ? mpb : pbit;
      @(negedge clk);
      vbase = vcnt;
      c0    = cyc;
      drive_bit(1'b0);
      if (flip) begin
         cfg_short  = ~sh;
         cfg_par_en = ~pe;
      end
      for (int i = 0; i < nb; i++) drive_bit(d[i]);
      if (extra) drive_bit(xb);
      drive_bit(~bad_stop[0]);
      if (two) drive_bit(~bad_stop[1]);
      rxd = 1'b1;
      repeat (2 * BITC) @(negedge clk);
      total = 1 + nb + (extra ? 1 : 0) + (two ? 2 : 1);
      lo    = c0 + ((total - 1) * 16 + 8) * TDIV;
      exp_d = dm;
      chk(vcnt == vbase + 1, "R8 one pulse per frame", vcnt - vbase, 1);
      chk(vcyc >= lo && vcyc <= lo + TDIV + 6, "R8 pulse timing", vcyc - c0, lo - c0);
      chk(cap_d == exp_d, sh ? "R4 7-bit data" : "R3 8-bit data", cap_d, exp_d);
      chk(cap_p == (pe && !mp && bad_par), "R5 parity flag", cap_p, pe && !mp && bad_par);
      chk(cap_f == (bad_stop[0] || (two && bad_stop[1])), "R7 framing flag",
          cap_f, bad_stop[0] || (two && bad_stop[1]));
      chk(cap_m == (mp && mpb), "R6 marker flag", cap_m, mp && mpb);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         nfail++;
         nvec++;
         $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      logic [7:0] dl [4];
      int vb;
      repeat (5) @(negedge clk);
      // R1: outputs cleared during and after reset
      chk(!rx_valid && rx_data == 8'h00 && !err_parity && !err_frame && !mp_flag,
          "R1 reset state (in reset)", {rx_valid, err_parity, err_frame, mp_flag, rx_data}, 0);
      rst_n = 1'b1;
      repeat (4 * BITC) @(negedge clk);
      chk(vcnt == 0 && rx_data == 8'h00 && !err_parity && !err_frame && !mp_flag,
          "R1 reset state (after release)", {vcnt[3:0], rx_data}, 0);

      // R2: glitch shorter than half a bit is dropped
      vb = vcnt;
      rxd = 1'b0;
      repeat (5 * TDIV) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * BITC) @(negedge clk);
      chk(vcnt == vb, "R2 short glitch rejected", vcnt - vb, 0);

      // R9: no tick, no frame
      tick_en = 1'b0;
      vb = vcnt;
      for (int i = 0; i < 12; i++) drive_bit(i[0]);
      rxd = 1'b1;
      repeat (BITC) @(negedge clk);
      chk(vcnt == vb, "R9 idle without tick", vcnt - vb, 0);
      tick_en = 1'b1;
      repeat (2 * BITC) @(negedge clk);

      // R3 R4 R5 R6 R7: clean frames across all configurations
      for (int m = 0; m < 32; m++) begin
         dl[0] = 8'h00; dl[1] = 8'hFF; dl[2] = 8'hA5; dl[3] = 8'(m * 37 + 11);
         for (int k = 0; k < 4; k++)
            run_frame(dl[k], 5'(m), 1'b0, 2'b00, dl[k][1], 1'b0);
      end

      // R5: corrupted parity bit, both senses, both lengths, both stop counts
      for (int s = 0; s < 2; s++)
         for (int t = 0; t < 2; t++)
            for (int o = 0; o < 2; o++)
               run_frame(8'h6B, {1'(s), 1'b1, 1'b0, 1'(t), 1'(o)}, 1'b1, 2'b00, 1'b0, 1'b0);

      // R7: each stop position sampled low
      for (int s = 0; s < 2; s++) begin
         run_frame(8'hC3, {1'(s), 4'b0000}, 1'b0, 2'b01, 1'b0, 1'b0);
         for (int b = 1; b < 4; b++)
            run_frame(8'h3C, {1'(s), 3'b001, 1'b0}, 1'b0, 2'(b), 1'b0, 1'b0);
      end

      // R6: marker bit set and clear, parity bit value irrelevant
      for (int m = 0; m < 16; m++)
         run_frame(8'h96, {m[3], m[2], 1'b1, m[1], m[0]}, 1'b0, 2'b00, m[0], 1'b0);

      // R10: configuration changed mid-frame has no effect
      run_frame(8'hD2, 5'b00000, 1'b0, 2'b00, 1'b0, 1'b1);
      run_frame(8'h81, 5'b01001, 1'b0, 2'b00, 1'b0, 1'b1);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule